// File: doc/BRIEF.md
# Interrupt translation table base register bank

This block holds the base registers that describe the in-memory tables of an interrupt translation unit. There are up to eight 64-bit registers. Each describes one table: where it starts in physical memory, how many pages it spans, the page granule, whether it is flat or two-level, and the memory attributes used to reach it. Software accesses the bank through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Each 64-bit register appears as two 32-bit words.

Each register has a fixed table kind that is set by its position and by build parameters. A register with no table behind it reads as zero and ignores all writes. The kind and the per-entry byte count are read-only. Reserved encodings of the shareability and page-granule fields are converted to legal values before they are stored. While the translation unit is enabled, or is not yet quiescent, every write is dropped.

The stored fields of every register are also brought out as decoded vectors for the table walker.

Top module: `itt_base_bank`

## Requirements
- R1: Register n (0..7) occupies byte offsets 0x100+8n (bits 31:0) and 0x104+8n (bits 63:32); address bit 2 selects the upper word. Every other offset reads as zero, and writes to it change no register.
- R2: A write to one 32-bit word of a register leaves the other word of that register unchanged.
- R3: The kind field, bits 58:56 (upper word bits 26:24), is read-only and ignores writes. Register 0 reports 001 (device). Register 1 reports 100 (collection) when that table is built in, otherwise 000. Register 2 reports 010 (vPE) when that table is built in, otherwise 000. Registers 3 to 7 report 000.
- R4: A register whose kind is 000 reads as zero in both words and ignores writes.
- R5: A write of 11 to the shareability field, bits 11:10, stores 00 and reads back as 00. Values 00, 01 and 10 are stored as written.
- R6: A write of 11 to the page-granule field, bits 9:8, stores 10 (64KB) and reads back as 10. Values 00 (4KB) and 01 (16KB) are stored as written.
- R7: The entry-size field, bits 52:48 (upper word bits 20:16), is read-only and returns a per-kind build constant: bytes per entry minus one.
- R8: While the enable input is 1, or the quiescent input is 0, no write changes any register.
- R9: After reset, every programmable field is zero. The programmable fields are valid[63], indirect[62], inner[61:59], outer[55:53], address[47:12], shareability, granule, and pages[7:0] (page count minus one).
- R10: The indirect bit is writable only in registers built for two-level tables. In other registers it reads as zero and ignores writes.
- R11: The decoded outputs carry each register's stored valid, indirect, attribute, address, granule and page-count fields, together with its kind and entry size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| unit_enable_i | input | 1 | Translation unit is enabled; blocks writes |
| unit_quiescent_i | input | 1 | Translation unit is idle; writes are allowed only when 1 |
| reg_addr_i | input | ADDR_W | Byte offset of the access |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| tbl_valid_o | output | NUM_REGS | Table memory allocated, per register |
| tbl_indirect_o | output | NUM_REGS | Two-level table, per register |
| tbl_kind_o | output | 3*NUM_REGS | Table kind, per register |
| tbl_esz_o | output | 5*NUM_REGS | Entry bytes minus one, per register |
| tbl_inner_o | output | 3*NUM_REGS | Inner cacheability, per register |
| tbl_outer_o | output | 3*NUM_REGS | Outer cacheability, per register |
| tbl_shr_o | output | 2*NUM_REGS | Shareability, per register |
| tbl_pgsz_o | output | 2*NUM_REGS | Page granule, per register |
| tbl_pa_o | output | 36*NUM_REGS | Table address bits 47:12, per register |
| tbl_pages_o | output | 8*NUM_REGS | Pages minus one, per register |

## Verification
The bench builds the bank with all eight registers and the collection table present. The vPE table is left out, so register 2 takes the absent-table path, and only register 0 allows two-level tables, so register 1 covers the flat-only indirect bit. Because the address window is small, every word offset from 0x000 to 0x1FC is read after reset and again after the write sweeps. Every register is written with all sixteen combinations of shareability and granule codes. Both write-lock conditions are driven against an implemented register.

// File: rtl/itt_base_pkg.sv
package itt_base_pkg;

  typedef enum logic [2:0] {
    TK_NONE = 3'b000,
    TK_DEV  = 3'b001,
    TK_VPE  = 3'b010,
    TK_COLL = 3'b100
  } tbl_kind_e;

  typedef struct packed {
    logic        valid;
    logic        indirect;
    logic [2:0]  inner;
    logic [2:0]  outer;
    logic [35:0] pa;
    logic [1:0]  shr;
    logic [1:0]  pg;
    logic [7:0]  pages;
  } tbl_cfg_t;

  function automatic tbl_kind_e kind_of(int idx, bit has_coll, bit has_vpe);
    case (idx)
      0:       return TK_DEV;
      1:       return has_coll ? TK_COLL : TK_NONE;
      2:       return has_vpe ? TK_VPE : TK_NONE;
      default: return TK_NONE;
    endcase
  endfunction

  function automatic logic [1:0] fold_shr(logic [1:0] v);
    return (v == 2'b11) ? 2'b00 : v;
  endfunction

  function automatic logic [1:0] fold_pg(logic [1:0] v);
    return (v == 2'b11) ? 2'b10 : v;
  endfunction

endpackage

// File: rtl/itt_base_decode.sv
module itt_base_decode #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h100,
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              upper_o
);
  localparam int SLOT_LSB = 3;
  localparam int WIN_LSB  = SLOT_LSB + IDX_W;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  assign hit_o   = (addr_i[ADDR_W-1:WIN_LSB] == BASE_V[ADDR_W-1:WIN_LSB]);
  assign idx_o   = addr_i[WIN_LSB-1:SLOT_LSB];
  assign upper_o = addr_i[2];
endmodule

// File: rtl/itt_base_entry.sv
module itt_base_entry
  import itt_base_pkg::*;
#(
  parameter int IDX       = 0,
  parameter bit HAS_COLL  = 1'b1,
  parameter bit HAS_VPE   = 1'b1,
  parameter bit TWO_LEVEL = 1'b0,
  parameter int DEV_ESZ   = 7,
  parameter int COLL_ESZ  = 15,
  parameter int VPE_ESZ   = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output tbl_cfg_t    cfg_o,
  output logic [2:0]  kind_o,
  output logic [4:0]  esz_o,
  output logic [31:0] lo_o,
  output logic [31:0] hi_o
);
  localparam tbl_kind_e KIND = kind_of(IDX, HAS_COLL, HAS_VPE);
  localparam bit IMPL = (KIND != TK_NONE);
  localparam logic [4:0] ESZ =
      (KIND == TK_DEV)  ? 5'(DEV_ESZ)  :
      (KIND == TK_COLL) ? 5'(COLL_ESZ) :
      (KIND == TK_VPE)  ? 5'(VPE_ESZ)  : 5'd0;

  tbl_cfg_t cfg_q;
  logic     wr_lo, wr_hi;
  logic     unused_ro;

  assign wr_lo     = wr_lo_i && IMPL;
  assign wr_hi     = wr_hi_i && IMPL;
  assign unused_ro = ^{wdata_i[26:24], wdata_i[20:16]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (wr_lo) begin
        cfg_q.pa[19:0] <= wdata_i[31:12];
        cfg_q.shr      <= fold_shr(wdata_i[11:10]);
        cfg_q.pg       <= fold_pg(wdata_i[9:8]);
        cfg_q.pages    <= wdata_i[7:0];
      end
      if (wr_hi) begin
        cfg_q.valid     <= wdata_i[31];
        cfg_q.indirect  <= wdata_i[30] & TWO_LEVEL;
        cfg_q.inner     <= wdata_i[29:27];
        cfg_q.outer     <= wdata_i[23:21];
        cfg_q.pa[35:20] <= wdata_i[15:0];
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign kind_o = KIND;
  assign esz_o  = ESZ;
  assign lo_o   = {cfg_q.pa[19:0], cfg_q.shr, cfg_q.pg, cfg_q.pages};
  assign hi_o   = {cfg_q.valid, cfg_q.indirect, cfg_q.inner, KIND,
                   cfg_q.outer, ESZ, cfg_q.pa[35:20]};

  a_r5_shr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.shr != 2'b11);
  a_r6_pg_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.pg != 2'b11);
  a_r2_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> (hi_o == $past(hi_o)));
  a_r2_lo_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> (lo_o == $past(lo_o)));
  a_r10_flat_ind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !TWO_LEVEL |-> !cfg_q.indirect);
endmodule

// File: rtl/itt_base_rdmux.sv
module itt_base_rdmux #(
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0][31:0] lo_i,
  input  logic [SLOTS-1:0][31:0] hi_i,
  input  logic                   hit_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic                   upper_i,
  output logic [31:0]            rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (hit_i) rdata_o = upper_i ? hi_i[idx_i] : lo_i[idx_i];
  end
endmodule

// File: rtl/itt_base_bank.sv
module itt_base_bank
  import itt_base_pkg::*;
#(
  parameter int           NUM_REGS       = 8,
  parameter int           ADDR_W         = 12,
  parameter int           BASE           = 'h100,
  parameter bit           HAS_COLL       = 1'b1,
  parameter bit           HAS_VPE        = 1'b1,
  parameter logic [7:0]   TWO_LEVEL_MASK = 8'h01,
  parameter int           DEV_ESZ        = 7,
  parameter int           COLL_ESZ       = 15,
  parameter int           VPE_ESZ        = 31
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     unit_enable_i,
  input  logic                     unit_quiescent_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic                     reg_we_i,
  input  logic [31:0]              reg_wdata_i,
  output logic [31:0]              reg_rdata_o,
  output logic [NUM_REGS-1:0]      tbl_valid_o,
  output logic [NUM_REGS-1:0]      tbl_indirect_o,
  output logic [3*NUM_REGS-1:0]    tbl_kind_o,
  output logic [5*NUM_REGS-1:0]    tbl_esz_o,
  output logic [3*NUM_REGS-1:0]    tbl_inner_o,
  output logic [3*NUM_REGS-1:0]    tbl_outer_o,
  output logic [2*NUM_REGS-1:0]    tbl_shr_o,
  output logic [2*NUM_REGS-1:0]    tbl_pgsz_o,
  output logic [36*NUM_REGS-1:0]   tbl_pa_o,
  output logic [8*NUM_REGS-1:0]    tbl_pages_o
);
  localparam int SLOTS = 8;
  localparam int IDX_W = $clog2(SLOTS);

  logic                   dec_hit, dec_upper, wr_ok;
  logic [IDX_W-1:0]       dec_idx;
  logic [SLOTS-1:0][31:0] lo_all, hi_all;
  logic [SLOTS-1:0]       slot_impl;
  tbl_cfg_t [NUM_REGS-1:0] cfg_all;

  itt_base_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .SLOTS(SLOTS)) u_dec (
    .addr_i (reg_addr_i),
    .hit_o  (dec_hit),
    .idx_o  (dec_idx),
    .upper_o(dec_upper)
  );

  // writes are dropped while the unit runs or drains
  assign wr_ok = reg_we_i && dec_hit && !unit_enable_i && unit_quiescent_i;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_REGS) begin : g_reg
      logic       wr_lo, wr_hi;
      logic [2:0] kind;
      logic [4:0] esz;
      assign wr_lo = wr_ok && (dec_idx == IDX_W'(i)) && !dec_upper;
      assign wr_hi = wr_ok && (dec_idx == IDX_W'(i)) &&  dec_upper;

      itt_base_entry #(
        .IDX(i), .HAS_COLL(HAS_COLL), .HAS_VPE(HAS_VPE),
        .TWO_LEVEL(TWO_LEVEL_MASK[i]),
        .DEV_ESZ(DEV_ESZ), .COLL_ESZ(COLL_ESZ), .VPE_ESZ(VPE_ESZ)
      ) u_entry (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_lo_i(wr_lo),
        .wr_hi_i(wr_hi),
        .wdata_i(reg_wdata_i),
        .cfg_o  (cfg_all[i]),
        .kind_o (kind),
        .esz_o  (esz),
        .lo_o   (lo_all[i]),
        .hi_o   (hi_all[i])
      );

      assign slot_impl[i]            = (kind != TK_NONE);
      assign tbl_valid_o[i]          = cfg_all[i].valid;
      assign tbl_indirect_o[i]       = cfg_all[i].indirect;
      assign tbl_kind_o[3*i +: 3]    = kind;
      assign tbl_esz_o[5*i +: 5]     = esz;
      assign tbl_inner_o[3*i +: 3]   = cfg_all[i].inner;
      assign tbl_outer_o[3*i +: 3]   = cfg_all[i].outer;
      assign tbl_shr_o[2*i +: 2]     = cfg_all[i].shr;
      assign tbl_pgsz_o[2*i +: 2]    = cfg_all[i].pg;
      assign tbl_pa_o[36*i +: 36]    = cfg_all[i].pa;
      assign tbl_pages_o[8*i +: 8]   = cfg_all[i].pages;
    end else begin : g_empty
      assign slot_impl[i] = 1'b0;
      assign lo_all[i]    = '0;
      assign hi_all[i]    = '0;
    end
  end

  itt_base_rdmux #(.SLOTS(SLOTS)) u_rd (
    .lo_i   (lo_all),
    .hi_i   (hi_all),
    .hit_i  (dec_hit),
    .idx_i  (dec_idx),
    .upper_i(dec_upper),
    .rdata_o(reg_rdata_o)
  );

  a_r8_write_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_enable_i || !unit_quiescent_i) |=> (cfg_all == $past(cfg_all)));
  a_r4_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_hit && !slot_impl[dec_idx]) |-> (reg_rdata_o == 32'h0));
  a_r1_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_hit |-> (reg_rdata_o == 32'h0));
  a_r1_miss_nowrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !dec_hit) |=> (cfg_all == $past(cfg_all)));
endmodule

// File: tb/itt_base_bank_tb.sv
`timescale 1ns/1ps
module itt_base_bank_tb;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, quiet = 1'b1, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] v_o, ind_o;
  logic [3*N-1:0] kind_o, inner_o, outer_o;
  logic [5*N-1:0] esz_o;
  logic [2*N-1:0] shr_o, pg_o;
  logic [36*N-1:0] pa_o;
  logic [8*N-1:0] pages_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];

  always #4 clk = ~clk;

  itt_base_bank #(.NUM_REGS(N), .HAS_COLL(1'b1), .HAS_VPE(1'b0),
                  .TWO_LEVEL_MASK(8'h01)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .unit_enable_i(en), .unit_quiescent_i(quiet),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tbl_valid_o(v_o), .tbl_indirect_o(ind_o), .tbl_kind_o(kind_o),
    .tbl_esz_o(esz_o), .tbl_inner_o(inner_o), .tbl_outer_o(outer_o),
    .tbl_shr_o(shr_o), .tbl_pgsz_o(pg_o), .tbl_pa_o(pa_o), .tbl_pages_o(pages_o)
  );

  function automatic bit impl(int n);  return n == 0 || n == 1; endfunction
  function automatic bit two_lv(int n); return n == 0; endfunction
  function automatic logic [2:0] kind(int n);
    return n == 0 ? 3'b001 : (n == 1 ? 3'b100 : 3'b000);
  endfunction
  function automatic logic [4:0] esz(int n);
    return n == 0 ? 5'd7 : (n == 1 ? 5'd15 : 5'd0);
  endfunction
  function automatic bit in_win(logic [11:0] a); return a[11:6] == 6'd4; endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    int n;
    if (!in_win(a)) return 32'h0;
    n = int'(a[5:3]);
    if (a[2]) return m_hi[n] | {5'b0, kind(n), 3'b0, esz(n), 16'b0};
    return m_lo[n];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    int n;
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (!en && quiet && in_win(a)) begin
      n = int'(a[5:3]);
      if (impl(n)) begin
        if (a[2])
          m_hi[n] = {d[31], d[30] & two_lv(n), d[29:27], 3'b0, d[23:21], 5'b0, d[15:0]};
        else
          m_lo[n] = {d[31:12], (d[11:10] == 2'b11) ? 2'b00 : d[11:10],
                     (d[9:8] == 2'b11) ? 2'b10 : d[9:8], d[7:0]};
      end
    end
  endtask

  task automatic rd_chk(string req, logic [11:0] a);
    @(negedge clk);
    addr = a; we = 1'b0;
    #2;
    chk(req, rdata, exp_rd(a));
  endtask

  task automatic sweep_all(string req);
    for (int a = 0; a < 'h200; a += 4) rd_chk(req, 12'(a));
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < N; n++) begin m_lo[n] = '0; m_hi[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 R3 R7 R1: reset image of every word offset
    sweep_all("R9_R3_R7_reset");

    // R5 R6 R4 R1: all shareability/granule codes on each register
    for (int n = 0; n < N; n++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++) begin
          wr(12'('h100 + 8*n), {12'(n*37 + s), 8'(p*16 + n), 2'(s), 2'(p), 8'(n*16 + s*4 + p)});
          rd_chk("R5_R6_R4_lo", 12'('h100 + 8*n));
        end

    // R2 R10 R3 R7: upper word writes, lower word kept
    for (int n = 0; n < N; n++) begin
      wr(12'('h104 + 8*n), 32'hFFFF_FFFF);
      rd_chk("R10_R3_R7_hi", 12'('h104 + 8*n));
      rd_chk("R2_lo_kept", 12'('h100 + 8*n));
      wr(12'('h104 + 8*n), 32'h4A5A_C3C3 ^ 32'(n));
      rd_chk("R10_R2_hi", 12'('h104 + 8*n));
      wr(12'('h100 + 8*n), 32'h1234_5E9D + 32'(n));
      rd_chk("R2_hi_kept", 12'('h104 + 8*n));
      rd_chk("R6_R5_lo", 12'('h100 + 8*n));
    end

    // R11: decoded outputs of registers 0 and 1
    @(negedge clk); #2;
    for (int n = 0; n < 2; n++) begin
      chk("R11_valid", 32'(v_o[n]), 32'(m_hi[n][31]));
      chk("R11_indirect", 32'(ind_o[n]), 32'(m_hi[n][30]));
      chk("R11_inner", 32'(inner_o[3*n +: 3]), 32'(m_hi[n][29:27]));
      chk("R11_outer", 32'(outer_o[3*n +: 3]), 32'(m_hi[n][23:21]));
      chk("R11_kind", 32'(kind_o[3*n +: 3]), 32'(kind(n)));
      chk("R11_esz", 32'(esz_o[5*n +: 5]), 32'(esz(n)));
      chk("R11_shr", 32'(shr_o[2*n +: 2]), 32'(m_lo[n][11:10]));
      chk("R11_pgsz", 32'(pg_o[2*n +: 2]), 32'(m_lo[n][9:8]));
      chk("R11_pages", 32'(pages_o[8*n +: 8]), 32'(m_lo[n][7:0]));
      chk("R11_pa_lo", 32'(pa_o[36*n +: 20]), 32'(m_lo[n][31:12]));
      chk("R11_pa_hi", 32'(pa_o[36*n + 20 +: 16]), 32'(m_hi[n][15:0]));
    end

    // R8: both lock conditions
    en = 1'b1;
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    rd_chk("R8_enable_lo", 12'h100);
    rd_chk("R8_enable_hi", 12'h104);
    en = 1'b0; quiet = 1'b0;
    wr(12'h108, 32'h0);
    wr(12'h10C, 32'h0);
    rd_chk("R8_busy_lo", 12'h108);
    rd_chk("R8_busy_hi", 12'h10C);
    quiet = 1'b1;

    // R1: writes outside the window touch nothing
    wr(12'h000, 32'h0);
    wr(12'h0F8, 32'h0);
    wr(12'h140, 32'h0);
    wr(12'h1FC, 32'h0);
    wr(12'h300, 32'h0);
    sweep_all("R1_R4_final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule